// File: doc/BRIEF.md
# SPI Buffer DMA Request Controller

This block sits beside a multi-buffered SPI sequencer and converts buffer transfer-complete events into DMA request pulses. It holds up to eight logical channels. Each channel has one 32-bit control word. The word names the buffer the channel watches, the physical request line its receive path drives, the physical request line its transmit path drives, two enables, a one-shot flag, a no-break flag and an initial count. Every time the sequencer reports a finished transfer on a watched buffer, each enabled path of that channel pulses its own line on a 16-line request bus.

In one-shot mode the channel sets the block length itself. It counts completed transfers and drops its own enables when the block is done. With no-break also set, the channel holds a burst-lock output so the sequencer serves only that buffer until the burst ends. A live count of the transfers that remain can be read back through the control word. If two enabled paths point at the same physical line, a sticky conflict flag is raised.

Top module: `spi_dma_req_ctrl`

## Requirements
- R1: After reset every control field and live count is zero, `dma_req` is all zero, and `map_conflict` and `burst_lock` are low.
- R2: The control word is laid out as follows. Bit 31 is one-shot. Bits 30:24 are the buffer id. Bits 23:20 are the receive line. Bits 19:16 are the transmit line. Bit 15 is the receive enable and bit 14 the transmit enable. Bit 13 is no-break. Bits 12:8 are the initial count. Bit 7 reads 0. Bits 6:0 are the live count. A write to channel `cfg_ch` stores bits 31:8, and `rd_word` shows the word of channel `rd_ch` in the same layout.
- R3: A cycle with `xfer_done` high and `xfer_buf` equal to a channel's buffer id raises, on the next cycle and for that one cycle, line `rx_map` when the receive enable is set and line `tx_map` when the transmit enable is set. Both pulses fall in the same cycle.
- R4: No request is issued when an enable is written, nor for a completion on a buffer that no enabled channel watches.
- R5: When a write sets an enable that was clear, the live count loads initial count plus one. Each matching completion while any enable is set lowers the count by one. The count stops at zero.
- R6: With one-shot set, the matching completion that finds the live count at 1 or 0 still issues its requests, and it clears both enables. No requests follow.
- R7: With one-shot clear, completions never change the enables.
- R8: Write data in bits 7:0 is ignored. Those bits always read as the reserved zero and the live count.
- R9: Requests from different paths that map to the same line are ORed onto that line.
- R10: `map_conflict` goes high one cycle after any two enabled paths share a physical line, and stays high until reset.
- R11: `burst_lock` is high while a channel has one-shot, no-break and at least one enable set. `burst_buf` then carries that channel's buffer id, with the lowest such channel index winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for a control word |
| cfg_ch | input | 3 | Channel index to write |
| cfg_wdata | input | 32 | Control word write data |
| rd_ch | input | 3 | Channel index to read back |
| rd_word | output | 32 | Control word of channel `rd_ch`, including the live count |
| xfer_done | input | 1 | Sequencer finished a buffer transfer this cycle |
| xfer_buf | input | 7 | Buffer id of the finished transfer |
| dma_req | output | 16 | Physical DMA request lines, one-cycle pulses |
| map_conflict | output | 1 | Sticky flag: two enabled paths shared a line |
| burst_lock | output | 1 | Burst in progress on a no-break one-shot channel |
| burst_buf | output | 7 | Buffer id the sequencer must stay on during a burst |

## Verification
Directed phases come first. A free-running channel receives a completion on a foreign buffer, then matching completions. This separates routing by buffer id from routing by line, and it shows the count saturating without touching the enables. A one-shot no-break channel is then run through its whole block, which shows that the last transfer still requests while the next one does not, and that the lock falls with the enables. A second channel is aimed at an occupied line to show the OR and the sticky flag. A long pseudo-random phase follows. It mixes writes, completions on a few shared buffer ids and readback of every channel, and each cycle is compared against a behavioural model. That phase covers write-versus-completion collisions and enable re-arming.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

    localparam int BUF_W     = 7;
    localparam int MAP_W     = 4;
    localparam int ICNT_W    = 5;
    localparam int LIVE_W    = ICNT_W + 2;
    localparam int NUM_LINES = 1 << MAP_W;
    localparam int WORD_W    = 32;

    // Upper 24 bits of the control word, MSB first
    typedef struct packed {
        logic              oneshot;
        logic [BUF_W-1:0]  buf_id;
        logic [MAP_W-1:0]  rx_map;
        logic [MAP_W-1:0]  tx_map;
        logic              rx_en;
        logic              tx_en;
        logic              no_break;
        logic [ICNT_W-1:0] init_cnt;
    } chan_cfg_t;

    function automatic chan_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        return chan_cfg_t'(w[WORD_W-1:WORD_W-$bits(chan_cfg_t)]);
    endfunction

    function automatic logic [WORD_W-1:0] word_pack(input chan_cfg_t c,
                                                    input logic [LIVE_W-1:0] cnt);
        return {c, 1'b0, cnt};
    endfunction

    function automatic logic path_active(input chan_cfg_t c);
        return c.rx_en | c.tx_en;
    endfunction

endpackage

// File: rtl/spi_dma_chan.sv
module spi_dma_chan
    import spi_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              done,
    input  logic [BUF_W-1:0]  done_buf,
    output chan_cfg_t         cfg,
    output logic [LIVE_W-1:0] live_cnt,
    output logic              rx_hit,
    output logic              tx_hit
);

    chan_cfg_t nxt;
    logic      match;
    logic      active;
    logic      rise;
    logic      last_xfer;

    always_comb begin
        nxt       = cfg_from_word(wr_word);
        match     = done && (done_buf == cfg.buf_id);
        active    = path_active(cfg);
        rise      = (nxt.rx_en & ~cfg.rx_en) | (nxt.tx_en & ~cfg.tx_en);
        last_xfer = (live_cnt <= LIVE_W'(1));
        rx_hit    = match & cfg.rx_en;
        tx_hit    = match & cfg.tx_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            live_cnt <= '0;
        end else if (wr_sel) begin
            cfg <= nxt;
            if (rise) begin
                live_cnt <= LIVE_W'(nxt.init_cnt) + LIVE_W'(1);
            end
        end else if (match && active) begin
            if (live_cnt != '0) begin
                live_cnt <= live_cnt - LIVE_W'(1);
            end
            if (cfg.oneshot && last_xfer) begin
                cfg.rx_en <= 1'b0;
                cfg.tx_en <= 1'b0;
            end
        end
    end

    // R6: one-shot channel drops its enables after its final transfer
    a_r6_oneshot_clears: assert property (@(posedge clk) disable iff (rst)
        (!wr_sel && match && active && cfg.oneshot && last_xfer)
        |=> !(cfg.rx_en || cfg.tx_en));

    // R7: free-running channel keeps its enables
    a_r7_rx_kept: assert property (@(posedge clk) disable iff (rst)
        (!wr_sel && !cfg.oneshot && cfg.rx_en) |=> cfg.rx_en);

    a_r7_tx_kept: assert property (@(posedge clk) disable iff (rst)
        (!wr_sel && !cfg.oneshot && cfg.tx_en) |=> cfg.tx_en);

    // R5: live count loads on an enable edge and never wraps below zero
    a_r5_count_load: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && rise) |=> (live_cnt == LIVE_W'($past(nxt.init_cnt)) + LIVE_W'(1)));

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (!wr_sel && live_cnt == '0) |=> (live_cnt == '0));

endmodule

// File: rtl/spi_dma_route.sv
module spi_dma_route
    import spi_dma_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  chan_cfg_t [NUM_CH-1:0]        cfg,
    input  logic [NUM_CH-1:0]             rx_hit,
    input  logic [NUM_CH-1:0]             tx_hit,
    output logic [NUM_LINES-1:0]          dma_req,
    output logic                          conflict
);

    localparam int USR_W = $clog2(2 * NUM_CH + 1);

    logic [NUM_LINES-1:0] req_d;
    logic [USR_W-1:0]     users;
    logic                 clash;

    always_comb begin
        req_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rx_hit[c]) req_d[cfg[c].rx_map] = 1'b1;
            if (tx_hit[c]) req_d[cfg[c].tx_map] = 1'b1;
        end
    end

    always_comb begin
        clash = 1'b0;
        users = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            users = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (cfg[c].rx_en && cfg[c].rx_map == MAP_W'(l)) users = users + USR_W'(1);
                if (cfg[c].tx_en && cfg[c].tx_map == MAP_W'(l)) users = users + USR_W'(1);
            end
            if (users > USR_W'(1)) clash = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_req  <= '0;
            conflict <= 1'b0;
        end else begin
            dma_req  <= req_d;
            conflict <= conflict | clash;
        end
    end

    // R10: conflict flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict);

    // R3: a hit always produces a request on the next cycle
    a_r3_hit_to_req: assert property (@(posedge clk) disable iff (rst)
        (|(rx_hit | tx_hit)) |=> (dma_req != '0));

endmodule

// File: rtl/spi_dma_burst.sv
module spi_dma_burst
    import spi_dma_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  chan_cfg_t [NUM_CH-1:0] cfg,
    output logic                   lock,
    output logic [BUF_W-1:0]       lock_buf
);

    always_comb begin
        lock     = 1'b0;
        lock_buf = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (cfg[c].oneshot && cfg[c].no_break && path_active(cfg[c])) begin
                lock     = 1'b1;
                lock_buf = cfg[c].buf_id;
            end
        end
    end

endmodule

// File: rtl/spi_dma_req_ctrl.sv
module spi_dma_req_ctrl
    import spi_dma_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [WORD_W-1:0]    cfg_wdata,
    input  logic [CH_W-1:0]      rd_ch,
    output logic [WORD_W-1:0]    rd_word,
    input  logic                 xfer_done,
    input  logic [BUF_W-1:0]     xfer_buf,
    output logic [NUM_LINES-1:0] dma_req,
    output logic                 map_conflict,
    output logic                 burst_lock,
    output logic [BUF_W-1:0]     burst_buf
);

    chan_cfg_t [NUM_CH-1:0]         cfg;
    logic [NUM_CH-1:0][LIVE_W-1:0]  live;
    logic [NUM_CH-1:0]              rx_hit;
    logic [NUM_CH-1:0]              tx_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        spi_dma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (cfg_wr && (cfg_ch == CH_W'(c))),
            .wr_word  (cfg_wdata),
            .done     (xfer_done),
            .done_buf (xfer_buf),
            .cfg      (cfg[c]),
            .live_cnt (live[c]),
            .rx_hit   (rx_hit[c]),
            .tx_hit   (tx_hit[c])
        );
    end

    spi_dma_route #(.NUM_CH(NUM_CH)) u_route (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .rx_hit   (rx_hit),
        .tx_hit   (tx_hit),
        .dma_req  (dma_req),
        .conflict (map_conflict)
    );

    spi_dma_burst #(.NUM_CH(NUM_CH)) u_burst (
        .cfg      (cfg),
        .lock     (burst_lock),
        .lock_buf (burst_buf)
    );

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c)) rd_word = word_pack(cfg[c], live[c]);
        end
    end

    // R4: requests only ever follow a completion event
    a_r4_req_needs_done: assert property (@(posedge clk) disable iff (rst)
        (dma_req != '0) |-> $past(xfer_done));

    // R8: reserved bit of the readback is always zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_word[7] == 1'b0);

endmodule

// File: tb/spi_dma_req_ctrl_test.sv
module spi_dma_req_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  rd_ch = '0;
    logic [31:0] rd_word;
    logic        xfer_done = 1'b0;
    logic [6:0]  xfer_buf = '0;
    logic [15:0] dma_req;
    logic        map_conflict;
    logic        burst_lock;
    logic [6:0]  burst_buf;

    always #2 clk = ~clk;

    spi_dma_req_ctrl uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
        .rd_ch(rd_ch), .rd_word(rd_word), .xfer_done(xfer_done), .xfer_buf(xfer_buf),
        .dma_req(dma_req), .map_conflict(map_conflict), .burst_lock(burst_lock),
        .burst_buf(burst_buf)
    );

    int errs = 0;
    int checks = 0;

    // behavioural reference state
    int m_os[8], m_buf[8], m_rxm[8], m_txm[8], m_rxe[8], m_txe[8], m_nb[8], m_ic[8], m_cnt[8];
    int exp_req = 0;
    int exp_conf = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_word(input int c);
        return (m_os[c] << 31) | (m_buf[c] << 24) | (m_rxm[c] << 20) | (m_txm[c] << 16) |
               (m_rxe[c] << 15) | (m_txe[c] << 14) | (m_nb[c] << 13) | (m_ic[c] << 8) |
               m_cnt[c];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 8; c++) begin
            m_os[c] = 0; m_buf[c] = 0; m_rxm[c] = 0; m_txm[c] = 0; m_rxe[c] = 0;
            m_txe[c] = 0; m_nb[c] = 0; m_ic[c] = 0; m_cnt[c] = 0;
        end
        exp_req = 0;
        exp_conf = 0;
    endtask

    task automatic model_step();
        int users[16];
        int req;
        req = 0;
        for (int l = 0; l < 16; l++) users[l] = 0;
        for (int c = 0; c < 8; c++) begin
            if (xfer_done && int'(xfer_buf) == m_buf[c]) begin
                if (m_rxe[c] != 0) req = req | (1 << m_rxm[c]);
                if (m_txe[c] != 0) req = req | (1 << m_txm[c]);
            end
            if (m_rxe[c] != 0) users[m_rxm[c]]++;
            if (m_txe[c] != 0) users[m_txm[c]]++;
        end
        for (int l = 0; l < 16; l++) if (users[l] > 1) exp_conf = 1;
        exp_req = req;
        for (int c = 0; c < 8; c++) begin
            if (cfg_wr && int'(cfg_ch) == c) begin
                int nrx, ntx;
                nrx = int'(cfg_wdata[15]);
                ntx = int'(cfg_wdata[14]);
                if ((nrx == 1 && m_rxe[c] == 0) || (ntx == 1 && m_txe[c] == 0))
                    m_cnt[c] = int'(cfg_wdata[12:8]) + 1;
                m_os[c]  = int'(cfg_wdata[31]);
                m_buf[c] = int'(cfg_wdata[30:24]);
                m_rxm[c] = int'(cfg_wdata[23:20]);
                m_txm[c] = int'(cfg_wdata[19:16]);
                m_rxe[c] = nrx;
                m_txe[c] = ntx;
                m_nb[c]  = int'(cfg_wdata[13]);
                m_ic[c]  = int'(cfg_wdata[12:8]);
            end else if (xfer_done && int'(xfer_buf) == m_buf[c] &&
                         (m_rxe[c] != 0 || m_txe[c] != 0)) begin
                int old;
                old = m_cnt[c];
                if (m_cnt[c] > 0) m_cnt[c]--;
                if (m_os[c] != 0 && old <= 1) begin
                    m_rxe[c] = 0;
                    m_txe[c] = 0;
                end
            end
        end
    endtask

    task automatic compare_all();
        int bl, bb;
        bl = 0; bb = 0;
        for (int c = 7; c >= 0; c--)
            if (m_os[c] != 0 && m_nb[c] != 0 && (m_rxe[c] != 0 || m_txe[c] != 0)) begin
                bl = 1; bb = m_buf[c];
            end
        chk("R3 R4 R6 R9 request lines", int'(dma_req), exp_req);
        chk("R2 R5 R7 R8 readback", int'(rd_word), model_word(int'(rd_ch)));
        chk("R10 conflict flag", int'(map_conflict), exp_conf);
        chk("R11 burst lock", int'(burst_lock), bl);
        if (bl != 0) chk("R11 burst buffer", int'(burst_buf), bb);
    endtask

    // inputs are set at a negedge; this advances one clock and compares
    task automatic tick();
        if (!rst) model_step();
        @(posedge clk);
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic wr(input int ch, input logic [31:0] w);
        cfg_wr = 1'b1; cfg_ch = 3'(ch); cfg_wdata = w;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic xfer(input int b);
        xfer_done = 1'b1; xfer_buf = 7'(b);
        tick();
        xfer_done = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int os, input int b, input int rxm, input int txm,
                                       input int rxe, input int txe, input int nb, input int ic,
                                       input int low);
        return 32'((os << 31) | (b << 24) | (rxm << 20) | (txm << 16) | (rxe << 15) |
                   (txe << 14) | (nb << 13) | (ic << 8) | (low & 8'hff));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        model_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 dma_req after reset", int'(dma_req), 0);
        chk("R1 readback after reset", int'(rd_word), 0);
        chk("R1 conflict after reset", int'(map_conflict), 0);
        chk("R1 burst lock after reset", int'(burst_lock), 0);

        // channel 0: free running, buffer 5, rx line 3, tx line 7, count 2, junk low bits
        rd_ch = 3'd0;
        wr(0, mk(0, 5, 3, 7, 1, 1, 0, 2, 8'hff));
        chk("R4 no request at enable", int'(dma_req), 0);
        chk("R2 R8 field layout", int'(rd_word), 32'h0537_C203);
        xfer(9);
        chk("R4 foreign buffer ignored", int'(dma_req), 0);
        xfer(5);
        chk("R3 rx and tx pulses together", int'(dma_req), 16'h0088);
        tick();
        chk("R3 single-cycle pulse", int'(dma_req), 0);
        chk("R5 count after one transfer", int'(rd_word[6:0]), 2);
        repeat (5) xfer(5);
        chk("R5 count saturates at zero", int'(rd_word[6:0]), 0);
        chk("R7 enables kept without one-shot", int'(rd_word[15:14]), 3);

        // channel 1: one-shot, no-break, buffer 10, rx line 2, tx line 4, count 1
        rd_ch = 3'd1;
        wr(1, mk(1, 10, 2, 4, 1, 1, 1, 1, 0));
        chk("R11 lock raised", int'(burst_lock), 1);
        chk("R11 lock buffer", int'(burst_buf), 10);
        chk("R5 one-shot count load", int'(rd_word[6:0]), 2);
        xfer(10);
        chk("R3 one-shot first pulse", int'(dma_req), 16'h0014);
        xfer(10);
        chk("R6 last transfer still requests", int'(dma_req), 16'h0014);
        chk("R6 enables cleared", int'(rd_word[15:14]), 0);
        chk("R11 lock released", int'(burst_lock), 0);
        xfer(10);
        chk("R6 no request after block", int'(dma_req), 0);

        // channel 2 shares rx line 3 with channel 0
        rd_ch = 3'd2;
        chk("R10 no conflict yet", int'(map_conflict), 0);
        wr(2, mk(0, 6, 3, 9, 1, 0, 0, 0, 0));
        tick();
        chk("R10 conflict raised", int'(map_conflict), 1);
        xfer(6);
        chk("R9 shared line via channel 2", int'(dma_req), 16'h0008);
        wr(2, mk(0, 6, 3, 9, 0, 0, 0, 0, 0));
        tick();
        chk("R10 conflict sticky", int'(map_conflict), 1);

        // pseudo-random mixed traffic
        lf = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rd_ch = lf[30:28];
            xfer_done = lf[8];
            xfer_buf = 7'(5 + int'(lf[27:26]));
            if (lf[2:0] == 3'd0) begin
                cfg_wr = 1'b1;
                cfg_ch = lf[5:3];
                cfg_wdata = mk(int'(lf[9]), 5 + int'(lf[11:10]), int'(lf[15:12]),
                               int'(lf[19:16]), int'(lf[20]), int'(lf[21]), int'(lf[22]),
                               int'(lf[25:23]), int'(lf[31:24]));
            end else begin
                cfg_wr = 1'b0;
            end
            tick();
        end
        cfg_wr = 1'b0;
        xfer_done = 1'b0;
        tick();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule